// File: doc/BRIEF.md
# Serial Auto-Baud Rate Detector

This block watches the receive line of an asynchronous serial link and learns its bit rate from a single synchronizing character. The expected character is uppercase 'U' (55h). Sent least significant bit first, 'U' toggles the line at every bit boundary. After software arms the detector, it times the span from the falling edge of the start bit to the eighth line edge that follows. That span covers eight bit periods. The detector turns the measurement into a reload value for an up-counting baud timer that oversamples each bit sixteen times. The link can then run at whatever rate the host picked, with no divisor tied to the oscillator.

A finished measurement raises a one-cycle done strobe and publishes the reload value, which stays put until a later measurement completes. The same strobe comes with an echo request, so the transmit side can send the synchronizing character back. Once locked, the detector uses the learned bit period to frame later characters. It raises one echo request for each start bit and ignores the data edges inside the character. A measurement that misses an edge, or that runs longer than a timeout, is thrown away, and the detector goes back to hunting for a start bit.

Top module: `autobaud_detect`

## Requirements
- R1: While reset is high and on the cycle after it, `done` and `echo_req` are 0 and `reload` is 0.
- R2: Before the first `arm` pulse, traffic on `rxd` (including a full 'U' character) produces no `done` pulse and leaves `reload` at 0.
- R3: After `arm`, a 'U' character (line idle high, start bit low, data bits sent LSB first, stop bit high) sets `reload` to (65536 - floor(N/128)) mod 65536. N is the number of clock cycles from the start-bit falling edge to the eighth line edge after it, which equals 8 bit periods.
- R4: `done` is a single-cycle pulse. It is visible in the third clock cycle after the eighth edge appears on `rxd`, counting the two synchronizer stages and the decision register.
- R5: `reload` changes only in a cycle where `done` is high. Neither characters received while locked nor a new `arm` alter it.
- R6: If, after the first edge of a measurement, no further edge comes within 1.5 times the first measured interval, the measurement is discarded and no `done` is produced. A following correct 'U' still locks.
- R7: If a measurement reaches TIMEOUT cycles before its eighth edge, the measurement is discarded and no `done` is produced. A following correct 'U' still locks.
- R8: `echo_req` pulses in the same cycle as `done`, so the synchronizing character can be sent back.
- R9: While locked, each later character produces exactly one `echo_req` pulse, in the third cycle after its start-bit falling edge. Falling edges within 9.5 learned bit periods of that start edge are ignored, and no further `done` occurs, whatever the data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-derived clock used to time bits |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Asynchronous serial receive line, idle high |
| arm | input | 1 | One-cycle request to start hunting for the synchronizing character |
| done | output | 1 | One-cycle strobe when a measurement completes |
| reload | output | 16 | Baud timer reload value (two's complement of bit period / 16) |
| echo_req | output | 1 | One-cycle request to echo a received character |

## Verification
Several properties are checked on every cycle. The done strobe never lasts two cycles, and it always comes with an echo request. The reload value never moves without done. While measuring, the running count stays below the timeout and the current edge gap stays within 1.5 times the first interval. Only the bench scenarios can show the numerical values: the exact reload for a range of bit periods, the exact cycle of each done and echo pulse, that malformed or stalled characters are discarded and then followed by a good lock, and that characters received while locked raise exactly one echo each, whatever their data.

// File: rtl/abd_pkg.sv
package abd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_MEAS,
        ST_LOCK
    } abd_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } abd_edge_t;

    // Two's-complement negation, used to turn a count into an up-counter reload.
    function automatic logic [31:0] abd_negate(input logic [31:0] v);
        return ~v + 32'd1;
    endfunction

endpackage

// File: rtl/abd_sync.sv
module abd_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rxd,
    output abd_pkg::abd_edge_t  edges
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;
    logic                   line;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= rxd;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[SYNC_STAGES-2:0], rxd};
            end
        end
    endgenerate

    assign line = chain[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= line;
    end

    always_comb begin
        edges.rise = line & ~prev;
        edges.fall = ~line & prev;
    end
endmodule

// File: rtl/abd_meas.sv
module abd_meas #(
    parameter int CNT_W     = 24,
    parameter int NUM_EDGES = 8,
    parameter int TIMEOUT   = 1000000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               arm,
    input  abd_pkg::abd_edge_t edges,
    output logic               finish,
    output logic [CNT_W-1:0]   span,
    output logic               done,
    output logic               echo_req
);
    import abd_pkg::*;

    localparam int EW  = $clog2(NUM_EDGES + 1);
    localparam int ESH = $clog2(NUM_EDGES);
    localparam logic [CNT_W-1:0] TMO = CNT_W'(TIMEOUT);

    abd_state_e       state;
    logic [CNT_W-1:0] total, gap, lim, bitper, blank;
    logic [CNT_W-1:0] tot_nx, gap_nx;
    logic [EW-1:0]    edge_cnt;
    logic             edge_any, expired;

    always_comb begin
        tot_nx   = total + 1'b1;
        gap_nx   = gap + 1'b1;
        edge_any = edges.rise | edges.fall;
        expired  = (tot_nx >= TMO);
        finish   = (state == ST_MEAS) && !arm && !expired && edge_any
                   && (edge_cnt == EW'(NUM_EDGES - 1));
        span     = tot_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            total    <= '0;
            gap      <= '0;
            lim      <= '0;
            bitper   <= '0;
            blank    <= '0;
            edge_cnt <= '0;
            done     <= 1'b0;
            echo_req <= 1'b0;
        end else begin
            done     <= 1'b0;
            echo_req <= 1'b0;
            if (arm) begin
                state <= ST_HUNT;
            end else begin
                case (state)
                    ST_HUNT: if (edges.fall) begin
                        state    <= ST_MEAS;
                        total    <= '0;
                        gap      <= '0;
                        edge_cnt <= '0;
                    end
                    ST_MEAS: begin
                        total <= tot_nx;
                        gap   <= gap_nx;
                        if (expired) begin
                            state <= ST_HUNT;
                        end else if (edge_any) begin
                            gap      <= '0;
                            edge_cnt <= edge_cnt + 1'b1;
                            if (edge_cnt == '0) lim <= gap_nx + (gap_nx >> 1);
                            if (finish) begin
                                state    <= ST_LOCK;
                                done     <= 1'b1;
                                echo_req <= 1'b1;
                                bitper   <= tot_nx >> ESH;
                                blank    <= (tot_nx >> ESH) + (tot_nx >> (ESH + 1));
                            end
                        end else if (edge_cnt != '0 && gap_nx > lim) begin
                            state <= ST_HUNT;
                        end
                    end
                    ST_LOCK: begin
                        if (blank != '0) begin
                            blank <= blank - 1'b1;
                        end else if (edges.fall) begin
                            echo_req <= 1'b1;
                            blank    <= (bitper << 3) + bitper + (bitper >> 1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8
    echo_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> echo_req);
    // R2
    done_source_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(state) == ST_MEAS);
    // R7
    meas_bound_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_MEAS |-> total < TMO);
    // R6
    gap_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MEAS && edge_cnt != '0) |-> gap <= lim);
endmodule

// File: rtl/abd_reload.sv
module abd_reload #(
    parameter int CNT_W = 24,
    parameter int RLD_W = 16,
    parameter int SHIFT = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] span,
    output logic [RLD_W-1:0] reload
);
    import abd_pkg::*;

    logic [31:0] per_tick;

    assign per_tick = 32'(span) >> SHIFT;

    always_ff @(posedge clk) begin
        if (rst)       reload <= '0;
        else if (load) reload <= RLD_W'(abd_negate(per_tick));
    end
endmodule

// File: rtl/autobaud_detect.sv
module autobaud_detect #(
    parameter int CNT_W       = 24,
    parameter int RLD_W       = 16,
    parameter int NUM_EDGES   = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT     = 1000000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rxd,
    input  logic             arm,
    output logic             done,
    output logic [RLD_W-1:0] reload,
    output logic             echo_req
);
    import abd_pkg::*;

    localparam int SHIFT = $clog2(NUM_EDGES) + $clog2(OVERSAMPLE);

    abd_edge_t        edges;
    logic             finish;
    logic [CNT_W-1:0] span;

    abd_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .rxd(rxd), .edges(edges)
    );

    abd_meas #(.CNT_W(CNT_W), .NUM_EDGES(NUM_EDGES), .TIMEOUT(TIMEOUT)) u_meas (
        .clk(clk), .rst(rst), .arm(arm), .edges(edges),
        .finish(finish), .span(span), .done(done), .echo_req(echo_req)
    );

    abd_reload #(.CNT_W(CNT_W), .RLD_W(RLD_W), .SHIFT(SHIFT)) u_reload (
        .clk(clk), .rst(rst), .load(finish), .span(span), .reload(reload)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!done && !echo_req && reload == '0));
    // R5
    reload_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(reload) |-> done);
endmodule

// File: tb/autobaud_detect_bench.sv
`timescale 1ns/1ps
module autobaud_detect_bench;
    localparam int TMO = 3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rxd = 1'b1;
    logic        arm = 1'b0;
    logic        done;
    logic [15:0] reload;
    logic        echo_req;

    int cyc = 0, n_chk = 0, n_bad = 0;
    int done_cnt = 0, done_cyc = 0, echo_cnt = 0, echo_cyc = 0;
    logic [15:0] done_rl = '0;

    always #10 clk = ~clk;

    autobaud_detect #(.TIMEOUT(TMO)) u_autobaud_detect (
        .clk(clk), .rst(rst), .rxd(rxd), .arm(arm),
        .done(done), .reload(reload), .echo_req(echo_req)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (done)     begin done_cnt++; done_cyc = cyc; done_rl = reload; end
        if (echo_req) begin echo_cnt++; echo_cyc = cyc; end
    end

    function automatic logic [15:0] exp_reload(input int p);
        int n = 8 * p;
        return 16'((65536 - (n / 128)) % 65536);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic idle(input int n);
        rxd = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_arm();
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
        done_cnt = 0; echo_cnt = 0;
    endtask

    task automatic send(input logic [7:0] b, input int p, output int st);
        @(negedge clk);
        st = cyc;
        rxd = 1'b0;
        repeat (p) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (p) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (p) @(negedge clk);
    endtask

    task automatic lock_check(input int p);
        int st;
        logic [15:0] e = exp_reload(p);
        do_arm();
        send(8'h55, p, st);
        idle(2 * p);
        chk(done_cnt == 1, "R4", done_cnt, 1);
        chk(done_cyc == st + 8 * p + 3, "R4", done_cyc, st + 8 * p + 3);
        chk(done_rl == e, "R3", done_rl, e);
        chk(reload == e, "R5", reload, e);
        chk(echo_cnt == 1 && echo_cyc == done_cyc, "R8", echo_cyc, done_cyc);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
        report();
    end

    initial begin
        int st, p, gapc;
        logic [15:0] held;
        logic [7:0]  b;
        void'($urandom(32'd1234));

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done == 1'b0 && echo_req == 1'b0, "R1", done, 0);
        chk(reload == 16'h0, "R1", reload, 0);
        rst = 1'b0;
        idle(5);

        // R2: unarmed detector ignores a full sync character
        send(8'h55, 32, st);
        idle(40);
        chk(done_cnt == 0, "R2", done_cnt, 0);
        chk(reload == 16'h0, "R2", reload, 0);

        // R3/R4/R8: directed extremes then random bit periods
        lock_check(16);
        lock_check(200);
        lock_check(128);
        for (int k = 0; k < 6; k++) lock_check(16 + int'($urandom_range(184)));

        // R9/R5: characters while locked
        p = 48;
        lock_check(p);
        held = reload;
        for (int k = 0; k < 8; k++) begin
            case (k)
                0: b = 8'h00;
                1: b = 8'hFF;
                2: b = 8'h55;
                default: b = 8'($urandom);
            endcase
            echo_cnt = 0; done_cnt = 0;
            gapc = int'($urandom_range(3 * p));
            if (gapc > 0) idle(gapc);
            send(b, p, st);
            chk(echo_cnt == 1, "R9", echo_cnt, 1);
            chk(echo_cyc == st + 3, "R9", echo_cyc, st + 3);
            chk(done_cnt == 0 && reload == held, "R5", reload, held);
        end

        // R5: a new arm alone leaves reload untouched
        do_arm();
        idle(50);
        chk(reload == held, "R5", reload, held);

        // R6: missing edge (57h) is discarded, then a good sync locks
        done_cnt = 0;
        send(8'h57, 40, st);
        idle(20 * 40);
        chk(done_cnt == 0, "R6", done_cnt, 0);
        chk(reload == held, "R6", reload, held);
        send(8'h55, 40, st);
        idle(80);
        chk(done_cnt == 1 && reload == exp_reload(40), "R6", reload, exp_reload(40));

        // R7: stalled start bit times out, then a good sync locks
        do_arm();
        held = reload;
        @(negedge clk); rxd = 1'b0;
        repeat (TMO + 200) @(negedge clk);
        idle(100);
        chk(done_cnt == 0 && reload == held, "R7", done_cnt, 0);
        send(8'h55, 50, st);
        idle(100);
        chk(done_cnt == 1 && done_cyc == st + 403, "R7", done_cyc, st + 403);
        chk(reload == exp_reload(50), "R7", reload, exp_reload(50));

        report();
    end
endmodule